// File: doc/BRIEF.md
# PCI Command Register with System-Error Gating

This block holds the 16-bit command register of a host bridge's PCI configuration space, together with the small amount of logic it controls. A configuration port writes the register one byte lane at a time and reads it back. Three bits can be written: memory access enable (bit 1), parity error enable (bit 6) and system error enable (bit 8). Bus master enable (bit 2) always reads as one. I/O access enable (bit 0) always reads as zero. Every other bit is reserved.

The register drives two functions. The first is the active-low system error output, which is registered. Four error-event pulses feed it: PCI parity, DRAM parity, cache parity and target abort. Each event has its own enable from a neighbouring error-command register. The three parity sources also need the parity error enable, but target abort does not. The system error enable is the master gate for all four. The second function is a memory-accept qualifier for cycles started by PCI masters. This qualifier is gated by the memory access enable. I/O cycles are never claimed.

Top module: `pci_cmd_ctl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the register reads 16'h0006 and serr_n is high.
- R2: Bits 15:9, bit 7 and bits 5:3 always read 0, and writes to them are ignored.
- R3: Bit 2 always reads 1 and bit 0 always reads 0, whatever value is written to them.
- R4: A write takes effect at the clock edge only when cfg_wr is high and cfg_addr equals 8'h04. cfg_be[0] enables bits 1 and 6, and cfg_be[1] enables bit 8.
- R5: While cfg_rd is high and cfg_addr equals 8'h04, cfg_rdata shows the current register value in the same cycle. Otherwise cfg_rdata is 0.
- R6: mem_accept is high exactly when bit 1 is 1, mst_mem_cyc is high and mem_decode_hit is high, all in the same cycle.
- R7: io_accept is always 0.
- R8: A parity event (PCI, DRAM or cache) drives serr_n low in the next cycle only if bit 8 = 1, bit 6 = 1 and that event's error-command enable is high.
- R9: A target abort with ecmd_tabort_en high and bit 8 = 1 drives serr_n low in the next cycle, whatever the value of bit 6.
- R10: While bit 8 = 0, serr_n stays high.
- R11: serr_n is low for exactly one cycle per cycle that has a qualifying event. Simultaneous events give a single low cycle. serr_n is high in every other cycle.
- R12: The gating uses the register value held before any write in the same cycle as the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_be | input | 2 | Byte-lane enables for writes |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data, combinational |
| ev_pci_par | input | 1 | PCI address/data parity error pulse |
| ev_dram_par | input | 1 | DRAM parity error pulse |
| ev_cache_par | input | 1 | Cache parity error pulse |
| ev_tgt_abort | input | 1 | Target abort on a bridge-initiated cycle |
| ecmd_pci_par_en | input | 1 | Error-command enable for PCI parity |
| ecmd_dram_par_en | input | 1 | Error-command enable for DRAM parity |
| ecmd_cache_par_en | input | 1 | Error-command enable for cache parity |
| ecmd_tabort_en | input | 1 | Error-command enable for target abort |
| mst_mem_cyc | input | 1 | A PCI master memory cycle is in progress |
| mem_decode_hit | input | 1 | Main-memory decode hit |
| mem_accept | output | 1 | The memory cycle is accepted |
| io_accept | output | 1 | I/O cycle claim (always 0) |
| serr_n | output | 1 | Registered active-low system error pulse |

## Verification
The system-error path is driven with random mixes of events, enables and register states. Seeded patterns separate the two kinds of gating: parity sources with bit 6 clear and target abort with bit 6 clear must give different results. Directed patterns fire all four sources in the same cycle to show that they merge into one pulse. Other directed patterns clear bit 8 in the same cycle as an event, which shows whether the gate uses the pre-write value. Random writes use every byte-enable combination, some with a wrong offset, and cover all-ones and all-zeros data. These show that lane gating, address decode and the hardwired bits are independent. Memory-accept checks go through every combination of enable, cycle and hit.

// File: rtl/pci_cmd_pkg.sv
// Package: bit positions, masks and shared types for the PCI command register.
// Assumes a 16-bit register. Only the bits in CMD_WR_MASK hold state.
package pci_cmd_pkg;
    localparam int CMD_W        = 16;
    localparam int CMD_LANES    = CMD_W / 8;
    localparam int BIT_IOAE     = 0;
    localparam int BIT_MAE      = 1;
    localparam int BIT_BME      = 2;
    localparam int BIT_PERRE    = 6;
    localparam int BIT_SERRE    = 8;
    localparam logic [CMD_W-1:0] CMD_WR_MASK  = (1 << BIT_MAE) | (1 << BIT_PERRE) | (1 << BIT_SERRE);
    localparam logic [CMD_W-1:0] CMD_HARD_ONE = (1 << BIT_BME);
    localparam logic [CMD_W-1:0] CMD_RST      = 16'h0006;

    // Error source indices. The parity sources also need the parity enable.
    localparam int ERR_PCI_PAR   = 0;
    localparam int ERR_DRAM_PAR  = 1;
    localparam int ERR_CACHE_PAR = 2;
    localparam int ERR_TABORT    = 3;
    localparam int N_ERR         = 4;
    localparam logic [N_ERR-1:0] ERR_PAR_MASK = 4'b0111;

    typedef struct packed {
        logic serre;
        logic perre;
        logic mae;
    } cmd_state_t;
endpackage

// File: rtl/pci_cmd_regs.sv
// Module: holds the writable command bits and produces the readback value.
// Assumes a synchronous active-low reset. Writes are decoded by offset and byte lane.
module pci_cmd_regs
    import pci_cmd_pkg::*;
#(
    parameter int               ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h04
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [CMD_LANES-1:0] cfg_be,
    input  logic [CMD_W-1:0]     cfg_wdata,
    output logic [CMD_W-1:0]     cfg_rdata,
    output cmd_state_t           state
);
    logic             hit;
    logic [CMD_W-1:0] lane_mask;
    logic [CMD_W-1:0] store_q;

    assign hit = (cfg_addr == REG_OFFSET);

    // Expand the byte enables into a bit mask of the writable bits.
    for (genvar g = 0; g < CMD_LANES; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = {8{cfg_be[g] & cfg_wr & hit}} & CMD_WR_MASK[g*8 +: 8];
    end

    // Store the writable bits and update them per lane.
    always_ff @(posedge clk) begin
        if (!rst_n) store_q <= CMD_RST & CMD_WR_MASK;
        else        store_q <= (store_q & ~lane_mask) | (cfg_wdata & lane_mask);
    end

    // Read back the stored bits with the hardwired bits forced.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_rd && hit) cfg_rdata = store_q | CMD_HARD_ONE;
    end

    assign state.serre = store_q[BIT_SERRE];
    assign state.perre = store_q[BIT_PERRE];
    assign state.mae   = store_q[BIT_MAE];
endmodule

// File: rtl/pci_cmd_serr.sv
// Module: qualifies the error events and registers one active-low SERR pulse.
// Assumes the events are single-cycle pulses. The gating uses the current (pre-write) state.
module pci_cmd_serr
    import pci_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_state_t       state,
    input  logic [N_ERR-1:0] ev,
    input  logic [N_ERR-1:0] en,
    output logic             serr_n
);
    logic [N_ERR-1:0] qual;
    logic             fire;

    // Parity sources need the parity enable; the other sources do not.
    for (genvar g = 0; g < N_ERR; g++) begin : g_src
        if (ERR_PAR_MASK[g]) begin : g_par
            assign qual[g] = ev[g] & en[g] & state.perre;
        end else begin : g_plain
            assign qual[g] = ev[g] & en[g];
        end
    end

    assign fire = state.serre & (|qual);

    // Register the merged request into the active-low output.
    always_ff @(posedge clk) begin
        if (!rst_n) serr_n <= 1'b1;
        else        serr_n <= ~fire;
    end
endmodule

// File: rtl/pci_cmd_memq.sv
// Module: qualifies memory cycles from PCI masters. I/O cycles are never claimed.
// Assumes mst_mem_cyc and mem_decode_hit are valid in the same cycle.
module pci_cmd_memq
    import pci_cmd_pkg::*;
(
    input  cmd_state_t state,
    input  logic       mst_mem_cyc,
    input  logic       mem_decode_hit,
    output logic       mem_accept,
    output logic       io_accept
);
    // Accept only when the memory enable is set.
    always_comb begin
        mem_accept = state.mae & mst_mem_cyc & mem_decode_hit;
        io_accept  = 1'b0;
    end
endmodule

// File: rtl/pci_cmd_ctl.sv
// Top: PCI command register with system-error gating and memory-accept qualification.
// Assumes a single clock and a synchronous active-low reset.
module pci_cmd_ctl
    import pci_cmd_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h04
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [CMD_LANES-1:0] cfg_be,
    input  logic [CMD_W-1:0]     cfg_wdata,
    output logic [CMD_W-1:0]     cfg_rdata,
    input  logic                 ev_pci_par,
    input  logic                 ev_dram_par,
    input  logic                 ev_cache_par,
    input  logic                 ev_tgt_abort,
    input  logic                 ecmd_pci_par_en,
    input  logic                 ecmd_dram_par_en,
    input  logic                 ecmd_cache_par_en,
    input  logic                 ecmd_tabort_en,
    input  logic                 mst_mem_cyc,
    input  logic                 mem_decode_hit,
    output logic                 mem_accept,
    output logic                 io_accept,
    output logic                 serr_n
);
    cmd_state_t       cmd_state;
    logic [N_ERR-1:0] ev_vec;
    logic [N_ERR-1:0] en_vec;

    // Gather the error sources in index order.
    always_comb begin
        ev_vec = '0;
        en_vec = '0;
        ev_vec[ERR_PCI_PAR]   = ev_pci_par;
        ev_vec[ERR_DRAM_PAR]  = ev_dram_par;
        ev_vec[ERR_CACHE_PAR] = ev_cache_par;
        ev_vec[ERR_TABORT]    = ev_tgt_abort;
        en_vec[ERR_PCI_PAR]   = ecmd_pci_par_en;
        en_vec[ERR_DRAM_PAR]  = ecmd_dram_par_en;
        en_vec[ERR_CACHE_PAR] = ecmd_cache_par_en;
        en_vec[ERR_TABORT]    = ecmd_tabort_en;
    end

    pci_cmd_regs #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .state(cmd_state)
    );

    pci_cmd_serr u_serr (
        .clk(clk), .rst_n(rst_n), .state(cmd_state), .ev(ev_vec), .en(en_vec), .serr_n(serr_n)
    );

    pci_cmd_memq u_memq (
        .state(cmd_state), .mst_mem_cyc(mst_mem_cyc), .mem_decode_hit(mem_decode_hit),
        .mem_accept(mem_accept), .io_accept(io_accept)
    );
endmodule

// File: rtl/pci_cmd_ctl_chk.sv
// Checker: temporal properties of the command register block, bound to the top.
// Assumes that the bind connects the internal command state.
module pci_cmd_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  cfg_addr,
    input logic        cfg_rd,
    input logic [15:0] cfg_rdata,
    input logic        ev_pci_par,
    input logic        ev_dram_par,
    input logic        ev_cache_par,
    input logic        ev_tgt_abort,
    input logic        ecmd_pci_par_en,
    input logic        ecmd_dram_par_en,
    input logic        ecmd_cache_par_en,
    input logic        ecmd_tabort_en,
    input logic        mem_accept,
    input logic        serr_n,
    input logic        serre,
    input logic        perre,
    input logic        mae
);
    logic tab_q;
    logic any_ev;
    assign tab_q  = ev_tgt_abort & ecmd_tabort_en;
    assign any_ev = ev_pci_par | ev_dram_par | ev_cache_par | ev_tgt_abort;

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == 8'h04) |-> ((cfg_rdata & 16'hFEB8) == 16'h0000));
    assert_hardwired_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == 8'h04) |-> (cfg_rdata[2] && !cfg_rdata[0]));
    assert_idle_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |-> (cfg_rdata == 16'h0000));
    assert_mem_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mae |-> !mem_accept);
    assert_parity_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (serre && perre && ((ev_pci_par && ecmd_pci_par_en) || (ev_dram_par && ecmd_dram_par_en)
         || (ev_cache_par && ecmd_cache_par_en))) |=> !serr_n);
    assert_parity_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!perre && !tab_q) |=> serr_n);
    assert_tabort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (serre && tab_q) |=> !serr_n);
    assert_serr_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !serre |=> serr_n);
    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ev |=> serr_n);
endmodule

bind pci_cmd_ctl pci_cmd_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
    .ev_pci_par(ev_pci_par), .ev_dram_par(ev_dram_par), .ev_cache_par(ev_cache_par),
    .ev_tgt_abort(ev_tgt_abort), .ecmd_pci_par_en(ecmd_pci_par_en),
    .ecmd_dram_par_en(ecmd_dram_par_en), .ecmd_cache_par_en(ecmd_cache_par_en),
    .ecmd_tabort_en(ecmd_tabort_en), .mem_accept(mem_accept), .serr_n(serr_n),
    .serre(cmd_state.serre), .perre(cmd_state.perre), .mae(cmd_state.mae)
);

// File: tb/pci_cmd_ctl_bench.sv
`timescale 1ns/1ps
module pci_cmd_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [1:0]  cfg_be = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        ev_pci_par = 0, ev_dram_par = 0, ev_cache_par = 0, ev_tgt_abort = 0;
    logic        en_pci = 0, en_dram = 0, en_cache = 0, en_tab = 0;
    logic        mst_mem_cyc = 0, mem_decode_hit = 0;
    logic        mem_accept, io_accept, serr_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic m_serre, m_perre, m_mae;

    always #2 clk = ~clk;

    pci_cmd_ctl u_pci_cmd_ctl (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ev_pci_par(ev_pci_par), .ev_dram_par(ev_dram_par), .ev_cache_par(ev_cache_par),
        .ev_tgt_abort(ev_tgt_abort), .ecmd_pci_par_en(en_pci), .ecmd_dram_par_en(en_dram),
        .ecmd_cache_par_en(en_cache), .ecmd_tabort_en(en_tab),
        .mst_mem_cyc(mst_mem_cyc), .mem_decode_hit(mem_decode_hit),
        .mem_accept(mem_accept), .io_accept(io_accept), .serr_n(serr_n)
    );

    function automatic logic [15:0] model_value();
        return {7'b0, m_serre, 1'b0, m_perre, 3'b0, 1'b1, m_mae, 1'b0};
    endfunction

    function automatic logic model_fire();
        logic par;
        par = (ev_pci_par & en_pci) | (ev_dram_par & en_dram) | (ev_cache_par & en_cache);
        return m_serre & ((m_perre & par) | (ev_tgt_abort & en_tab));
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cfg_wr = 0; cfg_rd = 0; cfg_be = 0; cfg_wdata = 0; cfg_addr = 0;
        ev_pci_par = 0; ev_dram_par = 0; ev_cache_par = 0; ev_tgt_abort = 0;
        mst_mem_cyc = 0; mem_decode_hit = 0;
    endtask

    // One cycle: inputs are already set at a falling edge.
    task automatic cycle(string stag);
        logic f;
        #1;
        check("R5 readback", cfg_rdata, (cfg_rd && cfg_addr == 8'h04) ? model_value() : 16'h0);
        check("R6 mem_accept", {15'b0, mem_accept}, {15'b0, m_mae & mst_mem_cyc & mem_decode_hit});
        check("R7 io_accept", {15'b0, io_accept}, 16'h0);
        f = model_fire();
        @(posedge clk);
        if (cfg_wr && cfg_addr == 8'h04) begin
            if (cfg_be[0]) begin m_mae = cfg_wdata[1]; m_perre = cfg_wdata[6]; end
            if (cfg_be[1]) m_serre = cfg_wdata[8];
        end
        @(negedge clk);
        check(stag, {15'b0, serr_n}, {15'b0, ~f});
    endtask

    task automatic wr(logic [7:0] a, logic [1:0] be, logic [15:0] d);
        idle(); cfg_addr = a; cfg_wr = 1; cfg_be = be; cfg_wdata = d;
        cycle("R11 serr idle");
    endtask

    task automatic rd(string tag);
        idle(); cfg_addr = 8'h04; cfg_rd = 1;
        #1;
        check(tag, cfg_rdata, model_value());
        cycle("R11 serr idle");
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0043));
        m_serre = 0; m_perre = 0; m_mae = 1;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check("R1 serr_n after reset", {15'b0, serr_n}, 16'h1);
        rd("R1 reset value");
        check("R1 literal 0006", model_value(), 16'h0006);

        // R2 R3 R4: write all ones, then read.
        wr(8'h04, 2'b11, 16'hFFFF);
        rd("R2 R3 all-ones write");
        wr(8'h04, 2'b11, 16'h0000);
        rd("R3 all-zeros write");
        // R4: wrong offset and lane gating.
        wr(8'h08, 2'b11, 16'hFFFF);
        rd("R4 wrong offset ignored");
        wr(8'h04, 2'b10, 16'hFFFF);
        rd("R4 upper lane only");
        wr(8'h04, 2'b01, 16'hFFFF);
        rd("R4 lower lane only");

        // R9: target abort with parity enable clear.
        wr(8'h04, 2'b11, 16'h0100);
        idle(); ev_tgt_abort = 1; en_tab = 1; cycle("R9 abort without perre");
        idle(); ev_pci_par = 1; en_pci = 1; cycle("R8 parity masked by perre");
        // R11: all sources at once give one pulse, then high.
        wr(8'h04, 2'b11, 16'h0140);
        idle(); ev_pci_par = 1; ev_dram_par = 1; ev_cache_par = 1; ev_tgt_abort = 1;
        en_pci = 1; en_dram = 1; en_cache = 1; en_tab = 1;
        cycle("R11 merged pulse");
        idle(); cycle("R11 pulse ends");
        // R12: clearing serre in the same cycle as an event still fires.
        idle(); cfg_addr = 8'h04; cfg_wr = 1; cfg_be = 2'b10; ev_dram_par = 1;
        cycle("R12 pre-write gating");
        // R10: serre now clear, so events are ignored.
        idle(); ev_tgt_abort = 1; ev_cache_par = 1; cycle("R10 serre off");

        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            idle();
            cfg_addr  = ($urandom % 4 != 0) ? 8'h04 : 8'($urandom);
            cfg_wr    = ($urandom % 4 == 0);
            cfg_rd    = ($urandom % 2 == 0);
            cfg_be    = 2'($urandom);
            cfg_wdata = 16'($urandom);
            ev_pci_par = ($urandom % 4 == 0); ev_dram_par = ($urandom % 4 == 0);
            ev_cache_par = ($urandom % 4 == 0); ev_tgt_abort = ($urandom % 4 == 0);
            en_pci = 1'($urandom); en_dram = 1'($urandom);
            en_cache = 1'($urandom); en_tab = 1'($urandom);
            mst_mem_cyc = 1'($urandom); mem_decode_hit = 1'($urandom);
            cycle("R8 R9 R10 random serr");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule